// File: doc/BRIEF.md
# Tamper Security State Controller

This block holds the security condition of a battery-backed monitor. Two flags describe it. The non-valid flag is raised whenever the battery domain is reset. The violation flag is raised by any tamper or counter-overflow event whose enable is set. With both flags clear the unit is valid, and the time and monotonic counters run. While either flag is set, a stop output holds those counters, and the violation flag can also raise an interrupt.

Software uses one write port to set up the unit. It enables event sources, sets lock bits and clears status with write-one-to-clear writes. The controller enforces the recovery sequence. A unit in failure with the non-valid flag clear accepts no recovery writes. A system reset turns it into non-valid plus failure. From there, software disables the sources and clears their sticky bits, then clears the violation flag, and clears the non-valid flag last. Lock bits control configuration changes and failure exit. A system reset releases the soft lock. Only a battery reset releases the hard locks.

Top module: `tamper_state_ctrl`

## Requirements
- R1: A battery reset (`bat_rst`, highest priority) leaves status equal to 0x00000002 (only the non-valid flag, bit 1), configuration 0, control 0 and the interrupt enable 0.
- R2: Tamper input i sets sticky status bit 16+i when configuration bit i is set. Time-counter overflow sets status bit 2 when configuration bit 8 is set. Monotonic overflow sets status bit 3 when configuration bit 9 is set. Each such event sets the violation flag (status bit 0) on the same edge. An event whose enable is clear is ignored. Gating uses the configuration held before the edge.
- R3: A status write (`wr_sel`=2) clears each of bits 2, 3 and 16..23 that it writes as 1. A new event on the same bit in the same cycle wins. Status and configuration writes are ignored while the violation flag is set and the non-valid flag is clear.
- R4: A system reset (`sys_rst`) sets the non-valid flag if the violation flag is set. It clears the soft lock and the interrupt enable. It leaves the sticky bits, the configuration and the hard locks unchanged.
- R5: Writing 1 to status bit 0 clears the violation flag only if all of these hold: the non-valid flag is set, control bit 16 (failure hard lock) is clear, and no sticky bit whose enable is set remains. An event in the same cycle keeps the flag set.
- R6: Writing 1 to status bit 1 clears the non-valid flag only while the violation flag is clear.
- R7: A configuration write (`wr_sel`=0) takes effect only with control bits 29 (soft lock) and 30 (hard lock) clear. A control write (`wr_sel`=1) can only set bits 16, 29 and 30. Bit 29 is released by a system reset. Bits 30 and 16 are released only by a battery reset.
- R8: `stop_o` is high exactly when either flag is set. `sv_irq_o` is high when the violation flag and interrupt enable bit 0 (written with `wr_sel`=3) are both set. Both outputs change on the same edge as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bat_rst | input | 1 | Battery-level reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 config, 1 control, 2 status, 3 interrupt enable |
| wr_data | input | 32 | Write data |
| tamper_in | input | NUM_TAMPER | Tamper sensor events |
| tc_ovf | input | 1 | Time-counter overflow event |
| mc_ovf | input | 1 | Monotonic-counter overflow event |
| status_o | output | 32 | Flags and sticky event bits |
| cfg_o | output | NUM_TAMPER+2 | Source enables |
| ctrl_o | output | 32 | Lock bits 16, 29, 30 |
| stop_o | output | 1 | Counter stop |
| sv_irq_o | output | 1 | Violation interrupt |

## Verification
Two functions can act in the same cycle. A sensor or overflow event can arrive while software writes a clear, either of the violation flag or of that event's sticky bit. The bench provokes this by driving a status clear together with an enabled event on the same edge. It expects the set to win: the sticky bit and the violation flag both read as set afterwards. A configuration write that coincides with an event is also driven, and the event must be gated by the old enables.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int STAT_W      = 32;
  localparam int SVF_BIT     = 0;
  localparam int NVF_BIT     = 1;
  localparam int TCO_BIT     = 2;
  localparam int MCO_BIT     = 3;
  localparam int TAMP_LSB    = 16;
  localparam int CTL_FAIL_HL = 16;
  localparam int CTL_CFG_SL  = 29;
  localparam int CTL_CFG_HL  = 30;
  localparam int IRQ_SV_BIT  = 0;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_IRQ  = 2'd3
  } wsel_e;
endpackage

// File: rtl/tsc_sticky_bank.sv
module tsc_sticky_bank #(
  parameter int SRC_W = 10
) (
  input  logic             clk,
  input  logic             bat_rst,
  input  logic             sys_rst,
  input  logic [SRC_W-1:0] src,
  input  logic [SRC_W-1:0] en,
  input  logic [SRC_W-1:0] clr_mask,
  input  logic             clr_ok,
  output logic [SRC_W-1:0] sticky_q,
  output logic [SRC_W-1:0] hit,
  output logic             pending
);
  // one capture cell per event source
  for (genvar i = 0; i < SRC_W; i++) begin : g_cell
    assign hit[i] = src[i] & en[i] & ~sys_rst;
    always_ff @(posedge clk) begin
      if (bat_rst)
        sticky_q[i] <= 1'b0;
      else if (!sys_rst)
        sticky_q[i] <= (sticky_q[i] & ~(clr_ok & clr_mask[i])) | hit[i];
    end
  end

  assign pending = |(sticky_q & en);
endmodule

// File: rtl/tsc_lock_regs.sv
module tsc_lock_regs
  import tsc_pkg::*;
#(
  parameter int CFG_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              bat_rst,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  wsel_e             wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fully_locked,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              soft_lock,
  output logic              hard_lock,
  output logic              fail_hl
);
  logic ctl_wr, cfg_wr;
  assign ctl_wr = wr_en && (wr_sel == SEL_CTL);
  assign cfg_wr = wr_en && (wr_sel == SEL_CFG) && !soft_lock && !hard_lock && !fully_locked;

  always_ff @(posedge clk) begin
    if (bat_rst) begin
      cfg_q     <= '0;
      soft_lock <= 1'b0;
      hard_lock <= 1'b0;
      fail_hl   <= 1'b0;
    end else if (sys_rst) begin
      soft_lock <= 1'b0;
    end else begin
      if (ctl_wr) begin
        soft_lock <= soft_lock | wr_data[CTL_CFG_SL];
        hard_lock <= hard_lock | wr_data[CTL_CFG_HL];
        fail_hl   <= fail_hl   | wr_data[CTL_FAIL_HL];
      end
      if (cfg_wr)
        cfg_q <= wr_data[CFG_W-1:0];
    end
  end
endmodule

// File: rtl/tsc_flag_ctrl.sv
module tsc_flag_ctrl
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              bat_rst,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  wsel_e             wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              any_hit,
  input  logic              pending,
  input  logic              fail_hl,
  output logic              svf_q,
  output logic              nvf_q,
  output logic              stop_q,
  output logic              irq_q
);
  logic ien_q;
  logic svf_d, nvf_d, ien_d;
  logic stat_wr;

  assign stat_wr = wr_en && (wr_sel == SEL_STAT);

  always_comb begin
    svf_d = svf_q;
    nvf_d = nvf_q;
    ien_d = ien_q;
    if (bat_rst) begin
      svf_d = 1'b0;
      nvf_d = 1'b1;
      ien_d = 1'b0;
    end else if (sys_rst) begin
      nvf_d = nvf_q | svf_q;
      ien_d = 1'b0;
    end else begin
      if (any_hit)
        svf_d = 1'b1;
      else if (stat_wr && wr_data[SVF_BIT] && nvf_q && !fail_hl && !pending)
        svf_d = 1'b0;
      if (stat_wr && wr_data[NVF_BIT] && !svf_q)
        nvf_d = 1'b0;
      if (wr_en && (wr_sel == SEL_IRQ))
        ien_d = wr_data[IRQ_SV_BIT];
    end
  end

  always_ff @(posedge clk) begin
    svf_q  <= svf_d;
    nvf_q  <= nvf_d;
    ien_q  <= ien_d;
    stop_q <= svf_d | nvf_d;
    irq_q  <= svf_d & ien_d;
  end
endmodule

// File: rtl/tamper_state_ctrl.sv
module tamper_state_ctrl
  import tsc_pkg::*;
#(
  parameter int NUM_TAMPER = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  bat_rst,
  input  logic                  sys_rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NUM_TAMPER-1:0] tamper_in,
  input  logic                  tc_ovf,
  input  logic                  mc_ovf,
  output logic [STAT_W-1:0]     status_o,
  output logic [NUM_TAMPER+1:0] cfg_o,
  output logic [STAT_W-1:0]     ctrl_o,
  output logic                  stop_o,
  output logic                  sv_irq_o
);
  localparam int SRC_W = NUM_TAMPER + 2;

  wsel_e            sel;
  logic [SRC_W-1:0] src, clr_mask, sticky, hit, cfg;
  logic             pending, svf, nvf, fully_locked, stat_clr_ok;
  logic             soft_lock, hard_lock, fail_hl;

  assign sel          = wsel_e'(wr_sel);
  assign src          = {mc_ovf, tc_ovf, tamper_in};
  assign clr_mask     = {wr_data[MCO_BIT], wr_data[TCO_BIT], wr_data[TAMP_LSB +: NUM_TAMPER]};
  assign fully_locked = svf & ~nvf;
  assign stat_clr_ok  = wr_en && (sel == SEL_STAT) && !fully_locked;

  tsc_sticky_bank #(.SRC_W(SRC_W)) bank_i (
    .clk(clk), .bat_rst(bat_rst), .sys_rst(sys_rst), .src(src), .en(cfg),
    .clr_mask(clr_mask), .clr_ok(stat_clr_ok), .sticky_q(sticky), .hit(hit),
    .pending(pending)
  );

  tsc_lock_regs #(.CFG_W(SRC_W), .DATA_W(DATA_W)) locks_i (
    .clk(clk), .bat_rst(bat_rst), .sys_rst(sys_rst), .wr_en(wr_en), .wr_sel(sel),
    .wr_data(wr_data), .fully_locked(fully_locked), .cfg_q(cfg),
    .soft_lock(soft_lock), .hard_lock(hard_lock), .fail_hl(fail_hl)
  );

  tsc_flag_ctrl #(.DATA_W(DATA_W)) flags_i (
    .clk(clk), .bat_rst(bat_rst), .sys_rst(sys_rst), .wr_en(wr_en && !fully_locked || sel != SEL_STAT && wr_en),
    .wr_sel(sel), .wr_data(wr_data), .any_hit(|hit), .pending(pending),
    .fail_hl(fail_hl), .svf_q(svf), .nvf_q(nvf), .stop_q(stop_o), .irq_q(sv_irq_o)
  );

  always_comb begin
    status_o                         = '0;
    status_o[SVF_BIT]                = svf;
    status_o[NVF_BIT]                = nvf;
    status_o[TCO_BIT]                = sticky[NUM_TAMPER];
    status_o[MCO_BIT]                = sticky[NUM_TAMPER+1];
    status_o[TAMP_LSB +: NUM_TAMPER] = sticky[NUM_TAMPER-1:0];
    ctrl_o                           = '0;
    ctrl_o[CTL_FAIL_HL]              = fail_hl;
    ctrl_o[CTL_CFG_SL]               = soft_lock;
    ctrl_o[CTL_CFG_HL]               = hard_lock;
  end

  assign cfg_o = cfg;
endmodule

// File: rtl/tamper_state_ctrl_chk.sv
module tamper_state_ctrl_chk #(
  parameter int NUM_TAMPER = 8
) (
  input logic                  clk,
  input logic                  bat_rst,
  input logic                  sys_rst,
  input logic [NUM_TAMPER-1:0] tamper_in,
  input logic [31:0]           status_o,
  input logic [NUM_TAMPER+1:0] cfg_o,
  input logic [31:0]           ctrl_o,
  input logic                  stop_o,
  input logic                  sv_irq_o
);
  assert_bat_state_R1: assert property (@(posedge clk)
    bat_rst |=> (status_o == 32'h2 && cfg_o == '0 && ctrl_o == 32'h0 && !sv_irq_o));

  assert_event_sets_violation_R2: assert property (@(posedge clk) disable iff (bat_rst)
    (!sys_rst && |(tamper_in & cfg_o[NUM_TAMPER-1:0])) |=> status_o[0]);

  assert_locked_failure_holds_R5: assert property (@(posedge clk) disable iff (bat_rst)
    (status_o[0] && !status_o[1]) |=> status_o[0]);

  assert_fail_hard_lock_R5: assert property (@(posedge clk) disable iff (bat_rst)
    (status_o[0] && ctrl_o[16]) |=> status_o[0]);

  assert_nvf_last_R6: assert property (@(posedge clk) disable iff (bat_rst)
    status_o[0] |=> !$fell(status_o[1]));

  assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (bat_rst)
    (ctrl_o[29] || ctrl_o[30]) |=> $stable(cfg_o));

  assert_hard_lock_sticky_R7: assert property (@(posedge clk) disable iff (bat_rst)
    ctrl_o[30] |=> ctrl_o[30]);

  assert_irq_needs_violation_R8: assert property (@(posedge clk) disable iff (bat_rst)
    sv_irq_o |-> status_o[0]);

  assert_stop_when_flagged_R8: assert property (@(posedge clk) disable iff (bat_rst)
    (status_o[0] || status_o[1]) |-> stop_o);
endmodule

bind tamper_state_ctrl tamper_state_ctrl_chk #(.NUM_TAMPER(NUM_TAMPER)) chk_i (
  .clk(clk), .bat_rst(bat_rst), .sys_rst(sys_rst), .tamper_in(tamper_in),
  .status_o(status_o), .cfg_o(cfg_o), .ctrl_o(ctrl_o), .stop_o(stop_o),
  .sv_irq_o(sv_irq_o)
);

// File: tb/tamper_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module tamper_state_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        bat_rst = 1'b1, sys_rst = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'h0;
  logic [7:0]  tamper_in = 8'h0;
  logic        tc_ovf = 1'b0, mc_ovf = 1'b0;
  logic [31:0] status_o, ctrl_o;
  logic [9:0]  cfg_o;
  logic        stop_o, sv_irq_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tamper_state_ctrl dut_i (
    .clk(clk), .bat_rst(bat_rst), .sys_rst(sys_rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tamper_in(tamper_in), .tc_ovf(tc_ovf), .mc_ovf(mc_ovf),
    .status_o(status_o), .cfg_o(cfg_o), .ctrl_o(ctrl_o), .stop_o(stop_o),
    .sv_irq_o(sv_irq_o)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic        sr, br, we;
    logic [1:0]  sel;
    logic [31:0] data;
    logic [7:0]  tamp;
    logic        tco, mco;
    logic [31:0] e_stat;
    logic [9:0]  e_cfg;
    logic        e_stop, e_irq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{"R1", 1'b0, 1'b1, 1'b0, 2'd0, 32'h0,     8'h00, 1'b0, 1'b0, 32'h00000002, 10'h000, 1'b1, 1'b0},
    '{"R7", 1'b0, 1'b0, 1'b1, 2'd0, 32'h3FF,   8'h00, 1'b0, 1'b0, 32'h00000002, 10'h3FF, 1'b1, 1'b0},
    '{"R8", 1'b0, 1'b0, 1'b1, 2'd3, 32'h1,     8'h00, 1'b0, 1'b0, 32'h00000002, 10'h3FF, 1'b1, 1'b0},
    '{"R6", 1'b0, 1'b0, 1'b1, 2'd2, 32'h2,     8'h00, 1'b0, 1'b0, 32'h00000000, 10'h3FF, 1'b0, 1'b0},
    '{"R2", 1'b0, 1'b0, 1'b0, 2'd0, 32'h0,     8'h04, 1'b0, 1'b0, 32'h00040001, 10'h3FF, 1'b1, 1'b1},
    '{"R2", 1'b0, 1'b0, 1'b0, 2'd0, 32'h0,     8'h00, 1'b0, 1'b0, 32'h00040001, 10'h3FF, 1'b1, 1'b1},
    '{"R3", 1'b0, 1'b0, 1'b1, 2'd2, 32'h40000, 8'h00, 1'b0, 1'b0, 32'h00040001, 10'h3FF, 1'b1, 1'b1},
    '{"R3", 1'b0, 1'b0, 1'b1, 2'd0, 32'h0,     8'h00, 1'b0, 1'b0, 32'h00040001, 10'h3FF, 1'b1, 1'b1},
    '{"R4", 1'b1, 1'b0, 1'b0, 2'd0, 32'h0,     8'h00, 1'b0, 1'b0, 32'h00040003, 10'h3FF, 1'b1, 1'b0},
    '{"R5", 1'b0, 1'b0, 1'b1, 2'd2, 32'h1,     8'h00, 1'b0, 1'b0, 32'h00040003, 10'h3FF, 1'b1, 1'b0},
    '{"R7", 1'b0, 1'b0, 1'b1, 2'd0, 32'h0,     8'h00, 1'b0, 1'b0, 32'h00040003, 10'h000, 1'b1, 1'b0},
    '{"R3", 1'b0, 1'b0, 1'b1, 2'd2, 32'h40000, 8'h00, 1'b0, 1'b0, 32'h00000003, 10'h000, 1'b1, 1'b0},
    '{"R6", 1'b0, 1'b0, 1'b1, 2'd2, 32'h2,     8'h00, 1'b0, 1'b0, 32'h00000003, 10'h000, 1'b1, 1'b0},
    '{"R5", 1'b0, 1'b0, 1'b1, 2'd2, 32'h1,     8'h00, 1'b0, 1'b0, 32'h00000002, 10'h000, 1'b1, 1'b0},
    '{"R6", 1'b0, 1'b0, 1'b1, 2'd2, 32'h2,     8'h00, 1'b0, 1'b0, 32'h00000000, 10'h000, 1'b0, 1'b0},
    '{"R2", 1'b0, 1'b0, 1'b0, 2'd0, 32'h0,     8'hFF, 1'b0, 1'b0, 32'h00000000, 10'h000, 1'b0, 1'b0},
    '{"R2", 1'b0, 1'b0, 1'b1, 2'd0, 32'h100,   8'h00, 1'b1, 1'b0, 32'h00000000, 10'h100, 1'b0, 1'b0},
    '{"R2", 1'b0, 1'b0, 1'b0, 2'd0, 32'h0,     8'h00, 1'b1, 1'b0, 32'h00000005, 10'h100, 1'b1, 1'b0}
  };

  task automatic chk(input logic [15:0] tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic sr, br, we, input logic [1:0] sel, input logic [31:0] data,
                       input logic [7:0] tamp, input logic tco, mco);
    sys_rst = sr; bat_rst = br; wr_en = we; wr_sel = sel; wr_data = data;
    tamper_in = tamp; tc_ovf = tco; mc_ovf = mco;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    drive(1'b0, 1'b0, 1'b1, sel, data, 8'h0, 1'b0, 1'b0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected under 20000", cyc);
      summary();
    end
  end

  initial begin
    drive(1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 8'h0, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 8'h0, 1'b0, 1'b0);
    chk("R1", "reset ctrl", ctrl_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].sr, TBL[i].br, TBL[i].we, TBL[i].sel, TBL[i].data,
            TBL[i].tamp, TBL[i].tco, TBL[i].mco);
      chk(TBL[i].tag, $sformatf("row %0d status", i), status_o, TBL[i].e_stat);
      chk(TBL[i].tag, $sformatf("row %0d cfg", i), {22'h0, cfg_o}, {22'h0, TBL[i].e_cfg});
      chk(TBL[i].tag, $sformatf("row %0d stop", i), {31'h0, stop_o}, {31'h0, TBL[i].e_stop});
      chk(TBL[i].tag, $sformatf("row %0d irq", i), {31'h0, sv_irq_o}, {31'h0, TBL[i].e_irq});
    end

    // R7 soft lock blocks config until system reset
    drive(1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 8'h0, 1'b0, 1'b0);
    wr(2'd1, 32'h2000_0000);
    chk("R7", "soft lock set", ctrl_o, 32'h2000_0000);
    wr(2'd0, 32'h3);
    chk("R7", "cfg blocked by soft lock", {22'h0, cfg_o}, 32'h0);
    drive(1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 8'h0, 1'b0, 1'b0);
    chk("R4", "soft lock released", ctrl_o, 32'h0);
    wr(2'd0, 32'h3);
    chk("R7", "cfg after release", {22'h0, cfg_o}, 32'h3);
    wr(2'd1, 32'h0);
    chk("R7", "ctrl write cannot clear", ctrl_o, 32'h0);

    // R7 hard lock survives system reset
    wr(2'd1, 32'h4000_0000);
    drive(1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 8'h0, 1'b0, 1'b0);
    chk("R7", "hard lock kept", ctrl_o, 32'h4000_0000);
    wr(2'd0, 32'h0);
    chk("R7", "cfg blocked by hard lock", {22'h0, cfg_o}, 32'h3);
    drive(1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 8'h0, 1'b0, 1'b0);
    chk("R1", "battery clears hard lock", ctrl_o, 32'h0);
    chk("R1", "battery clears cfg", {22'h0, cfg_o}, 32'h0);

    // R5 failure hard lock keeps the violation flag
    wr(2'd2, 32'h2);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h0001_0000);
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 8'h01, 1'b0, 1'b0);
    chk("R2", "tamper0 captured", status_o, 32'h0001_0001);
    drive(1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 8'h0, 1'b0, 1'b0);
    chk("R4", "system reset to nonvalid+failure", status_o, 32'h0001_0003);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0001_0000);
    chk("R3", "tamper bit cleared", status_o, 32'h3);
    wr(2'd2, 32'h1);
    chk("R5", "violation held by hard lock", status_o, 32'h3);
    drive(1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 8'h0, 1'b0, 1'b0);
    chk("R1", "battery leaves failure", status_o, 32'h2);

    // same-cycle collisions: set beats clear
    wr(2'd2, 32'h2);
    wr(2'd0, 32'h1);
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 8'h01, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 8'h0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 2'd2, 32'h0001_0000, 8'h01, 1'b0, 1'b0);
    chk("R3", "event wins over bit clear", status_o, 32'h0001_0003);
    wr(2'd0, 32'h200);
    wr(2'd2, 32'h0001_0000);
    chk("R3", "bit clear after disable", status_o, 32'h3);
    drive(1'b0, 1'b0, 1'b1, 2'd2, 32'h1, 8'h0, 1'b0, 1'b1);
    chk("R5", "event wins over violation clear", status_o, 32'hB);
    wr(2'd3, 32'h1);
    chk("R8", "irq with violation and enable", {31'h0, sv_irq_o}, 32'h1);
    chk("R8", "stop while flagged", {31'h0, stop_o}, 32'h1);

    summary();
  end
endmodule